// File: doc/BRIEF.md
# Threshold FIFO with Service Request

This block is a byte FIFO of 16 entries sitting between a device-side byte stream and a host in a programmed-I/O transfer. One side writes and the other reads. Which side is the host depends on a direction setting: when data flows to the host, the device writes and the host reads. When data flows from the host, the host writes and the device reads. A single output, `req_o`, tells the host that it should service the FIFO. It can drive an interrupt line and can also be polled as a status bit.

A configuration strobe loads three things at once: an enable, a 4-bit threshold code and the direction. The threshold is the number of bytes the host may move per service request, and the code holds that number minus one. With the FIFO disabled (the state after reset), the FIFO holds one byte and every byte gets its own request. The request is hysteretic. It asserts when the threshold is reached, or when an end-of-sector pulse asks for a flush. It then stays up until the host has completely emptied the FIFO (toward the host) or completely filled it (from the host).

Top module: `svc_fifo`

## Requirements
- R1: After reset the FIFO is disabled, the direction is toward the host (`cfg_dir_i` code 0), `count_o` is 0, `empty_o` is 1, and `full_o`, `req_o` and `err_o` are 0.
- R2: With the FIFO disabled and the direction toward the host, capacity is one byte. `req_o` is 1 exactly while that byte is held.
- R3: With the FIFO disabled and the direction from the host (`cfg_dir_i` code 1), capacity is one byte. `req_o` is 1 exactly while the FIFO is empty.
- R4: A cycle with `cfg_valid_i` high loads the enable, the threshold code and the direction. It empties the FIFO and clears the flush flag. Any read or write in that cycle is dropped without setting the error flag. `req_o` in the following cycle follows the new setting applied to an empty FIFO.
- R5: Bytes leave in the order they were accepted. `rd_data_o` always shows the oldest byte held, and a read and a write in the same cycle are both accepted when legal.
- R6: When enabled with the direction toward the host, `req_o` rises in the cycle after the occupancy first reaches at least 16 minus (code+1).
- R7: When enabled with the direction toward the host, once `req_o` is high it stays high until the FIFO becomes empty, and it is 0 whenever the FIFO is empty.
- R8: A one-cycle `sector_end_i` pulse sets a flush flag. While the flag is set and the FIFO is not empty, `req_o` is high in the toward-host direction. The flag clears when the FIFO becomes empty.
- R9: When enabled with the direction from the host, `req_o` is high while the free space is at least code+1. Once high, it stays high until the FIFO is full, and it is 0 whenever the FIFO is full.
- R10: A read of an empty FIFO or a write to a full FIFO changes neither the contents nor the count, and sets `err_o`. `err_o` then stays 1 until reset.
- R11: `count_o` gives the occupancy, from 0 to 16. `empty_o` is 1 at count 0. `full_o` is 1 at count 16 when enabled and at count 1 when disabled. All three update in the cycle after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_valid_i | input | 1 | Configuration load strobe |
| cfg_en_i | input | 1 | FIFO enable loaded on the strobe |
| cfg_thr_i | input | 4 | Threshold code (threshold minus one) |
| cfg_dir_i | input | 1 | Direction: 0 toward host, 1 from host |
| wr_i | input | 1 | Write strobe from the producing side |
| wr_data_i | input | 8 | Write byte |
| rd_i | input | 1 | Read strobe from the consuming side |
| rd_data_o | output | 8 | Oldest byte held (show-ahead) |
| sector_end_i | input | 1 | One-cycle pulse: last bytes of a sector are loaded |
| req_o | output | 1 | Service request / interrupt |
| full_o | output | 1 | FIFO at capacity |
| empty_o | output | 1 | FIFO empty |
| count_o | output | 5 | Occupancy |
| err_o | output | 1 | Sticky overflow/underflow flag |

## Verification
The properties assume that direction and enable change only through the configuration strobe, and that the occupancy moves by at most one per cycle outside a configuration cycle. The stimulus writes configuration only through `cfg_valid_i` and issues at most one read and one write per cycle. Deliberate reads of an empty FIFO and writes to a full FIFO are placed to drive the error flag. A randomized phase mixes reads, writes and sector-end pulses under a fixed threshold, and a behavioural queue model predicts every output on every cycle.

// File: rtl/svc_fifo_pkg.sv
package svc_fifo_pkg;
  typedef enum logic {
    DIR_TO_HOST   = 1'b0,
    DIR_FROM_HOST = 1'b1
  } dir_e;
endpackage

// File: rtl/svc_fifo_store.sv
module svc_fifo_store #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] data_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wp_q, rp_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= data_i;
  end

  // power-of-two depth: pointers wrap naturally
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
      rp_q <= '0;
    end else if (clr_i) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (push_i) wp_q <= wp_q + AW'(1);
      if (pop_i)  rp_q <= rp_q + AW'(1);
    end
  end

  assign data_o = mem_q[rp_q];
endmodule

// File: rtl/svc_fifo_level.sv
module svc_fifo_level #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic          wr_i,
  input  logic          rd_i,
  output logic          push_o,
  output logic          pop_o,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cnt_n_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          err_o
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [CW-1:0] cnt_q;
  logic          err_q;

  assign empty_o = (cnt_q == '0);
  assign full_o  = en_i ? (cnt_q == DEPTH_C) : (cnt_q == CW'(1));
  assign push_o  = wr_i & ~full_o & ~clr_i;
  assign pop_o   = rd_i & ~empty_o & ~clr_i;
  assign cnt_n_o = clr_i ? '0 : cnt_q + CW'(push_o) - CW'(pop_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n_o;
      if (!clr_i && ((wr_i && full_o) || (rd_i && empty_o))) err_q <= 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign err_o = err_q;
endmodule

// File: rtl/svc_fifo_req.sv
module svc_fifo_req
  import svc_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_n_i,
  input  logic [AW-1:0] thr_n_i,
  input  dir_e          dir_n_i,
  input  logic [CW-1:0] cnt_n_i,
  input  logic          sector_end_i,
  output logic          req_o
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic          req_q, flush_q;
  logic          req_n, flush_n, req_hold;
  logic [CW-1:0] thr_bytes, free_n;

  assign thr_bytes = CW'(thr_n_i) + CW'(1);
  assign free_n    = DEPTH_C - cnt_n_i;

  always_comb begin
    flush_n  = (clr_i || cnt_n_i == '0) ? 1'b0 : (flush_q | sector_end_i);
    req_hold = clr_i ? 1'b0 : req_q;
    if (dir_n_i == DIR_TO_HOST) begin
      if (!en_n_i)              req_n = (cnt_n_i != '0);
      else if (cnt_n_i == '0)   req_n = 1'b0;
      else                      req_n = req_hold | (cnt_n_i >= DEPTH_C - thr_bytes) | flush_n;
    end else begin
      if (!en_n_i)              req_n = (cnt_n_i == '0);
      else if (cnt_n_i == DEPTH_C) req_n = 1'b0;
      else                      req_n = req_hold | (free_n >= thr_bytes);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      req_q   <= req_n;
      flush_q <= flush_n;
    end
  end

  assign req_o = req_q;
endmodule

// File: rtl/svc_fifo.sv
module svc_fifo
  import svc_fifo_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_valid_i,
  input  logic             cfg_en_i,
  input  logic [AW-1:0]    cfg_thr_i,
  input  logic             cfg_dir_i,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_i,
  output logic [WIDTH-1:0] rd_data_o,
  input  logic             sector_end_i,
  output logic             req_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [CW-1:0]    count_o,
  output logic             err_o
);
  logic          en_q, en_n;
  logic [AW-1:0] thr_q, thr_n;
  dir_e          dir_q, dir_n;
  logic          push, pop;
  logic [CW-1:0] cnt_n;

  assign en_n  = cfg_valid_i ? cfg_en_i : en_q;
  assign thr_n = cfg_valid_i ? cfg_thr_i : thr_q;
  assign dir_n = cfg_valid_i ? dir_e'(cfg_dir_i) : dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      thr_q <= '0;
      dir_q <= DIR_TO_HOST;
    end else begin
      en_q  <= en_n;
      thr_q <= thr_n;
      dir_q <= dir_n;
    end
  end

  svc_fifo_level #(.DEPTH(DEPTH)) level_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (cfg_valid_i),
    .en_i    (en_q),
    .wr_i    (wr_i),
    .rd_i    (rd_i),
    .push_o  (push),
    .pop_o   (pop),
    .cnt_o   (count_o),
    .cnt_n_o (cnt_n),
    .full_o  (full_o),
    .empty_o (empty_o),
    .err_o   (err_o)
  );

  svc_fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) store_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cfg_valid_i),
    .push_i (push),
    .pop_i  (pop),
    .data_i (wr_data_i),
    .data_o (rd_data_o)
  );

  svc_fifo_req #(.DEPTH(DEPTH)) req_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (cfg_valid_i),
    .en_n_i       (en_n),
    .thr_n_i      (thr_n),
    .dir_n_i      (dir_n),
    .cnt_n_i      (cnt_n),
    .sector_end_i (sector_end_i),
    .req_o        (req_o)
  );
endmodule

// File: rtl/svc_fifo_chk.sv
module svc_fifo_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_valid_i,
  input logic          en_i,
  input logic          dir_i,
  input logic          req_o,
  input logic          full_o,
  input logic          empty_o,
  input logic          err_o,
  input logic [CW-1:0] count_o
);
  a_r11_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(count_o) <= int'(DEPTH));

  a_r11_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_valid_i |=> (int'(count_o) <= int'($past(count_o)) + 1) &&
                     (int'(count_o) + 1 >= int'($past(count_o))));

  a_r10_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  a_r7_no_req_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir_i && empty_o) |-> !req_o);

  a_r7_hold_until_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !dir_i && req_o && !cfg_valid_i) |=> (req_o || empty_o));

  a_r9_drop_at_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && dir_i && full_o) |-> !req_o);

  a_r3_req_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && dir_i && empty_o) |-> req_o);
endmodule

bind svc_fifo svc_fifo_chk #(.DEPTH(DEPTH)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_valid_i (cfg_valid_i),
  .en_i        (en_q),
  .dir_i       (dir_q),
  .req_o       (req_o),
  .full_o      (full_o),
  .empty_o     (empty_o),
  .err_o       (err_o),
  .count_o     (count_o)
);

// File: tb/svc_fifo_tb_top.sv
module svc_fifo_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_valid_i = 1'b0, cfg_en_i = 1'b0, cfg_dir_i = 1'b0;
  logic [3:0] cfg_thr_i = '0;
  logic       wr_i = 1'b0, rd_i = 1'b0, sector_end_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic       req_o, full_o, empty_o, err_o;
  logic [4:0] count_o;

  always #10 clk_i = ~clk_i;  // 50 MHz

  svc_fifo dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_valid_i(cfg_valid_i), .cfg_en_i(cfg_en_i),
    .cfg_thr_i(cfg_thr_i), .cfg_dir_i(cfg_dir_i), .wr_i(wr_i), .wr_data_i(wr_data_i),
    .rd_i(rd_i), .rd_data_o(rd_data_o), .sector_end_i(sector_end_i), .req_o(req_o),
    .full_o(full_o), .empty_o(empty_o), .count_o(count_o), .err_o(err_o)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural reference
  bit       m_en = 0, m_dir = 0, m_flush = 0, m_req = 0, m_err = 0;
  int       m_thr = 0;
  byte      q[$];
  logic [7:0] wdat = 8'h10;

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic void model_step();
    int n, cap;
    bit full, empty;
    if (cfg_valid_i) begin
      m_en = cfg_en_i; m_thr = int'(cfg_thr_i) + 1; m_dir = cfg_dir_i;
      q.delete(); m_flush = 0; m_req = 0;
    end else begin
      cap   = m_en ? 16 : 1;
      full  = (q.size() == cap);
      empty = (q.size() == 0);
      if ((rd_i && empty) || (wr_i && full)) m_err = 1;
      if (rd_i && !empty) void'(q.pop_front());
      if (wr_i && !full) q.push_back(wr_data_i);
    end
    n = q.size();
    m_flush = (n == 0 || cfg_valid_i) ? 0 : (m_flush | sector_end_i);
    if (!m_dir) begin
      if (!m_en) m_req = (n != 0);
      else if (n == 0) m_req = 0;
      else m_req = m_req | (n >= 16 - m_thr) | m_flush;
    end else begin
      if (!m_en) m_req = (n == 0);
      else if (n == 16) m_req = 0;
      else m_req = m_req | ((16 - n) >= m_thr);
    end
  endfunction

  function automatic string req_tag();
    if (!m_en) return m_dir ? "R3" : "R2";
    if (m_dir) return "R9";
    return m_flush ? "R8" : "R6 R7";
  endfunction

  task automatic compare();
    int cap = m_en ? 16 : 1;
    check(count_o == 5'(q.size()), "R11", "count", count_o, q.size());
    check(empty_o == (q.size() == 0), "R11", "empty", empty_o, q.size() == 0);
    check(full_o == (q.size() == cap), "R11", "full", full_o, q.size() == cap);
    check(req_o == m_req, req_tag(), "req", req_o, m_req);
    check(err_o == m_err, "R10", "err", err_o, m_err);
    if (q.size() != 0)
      check(rd_data_o == q[0], "R5", "rd_data", rd_data_o, q[0]);
  endtask

  // one clock: model follows the edge, outputs compared at the falling edge
  task automatic cyc();
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
    compare();
    cfg_valid_i = 0; wr_i = 0; rd_i = 0; sector_end_i = 0;
  endtask

  task automatic wr(); wr_i = 1; wr_data_i = wdat; wdat = wdat + 8'd1; cyc(); endtask
  task automatic rd(); rd_i = 1; cyc(); endtask
  task automatic cfg(input bit en, input int code, input bit dir);
    cfg_valid_i = 1; cfg_en_i = en; cfg_thr_i = 4'(code); cfg_dir_i = dir;
    wr_i = 1; wr_data_i = 8'hEE;  // dropped in a configuration cycle
    cyc();
    check(count_o == 0 && err_o == m_err, "R4", "clear on configure", count_o, 0);
  endtask

  initial begin
    @(negedge clk_i);
    check(count_o == 0 && empty_o && !full_o && !req_o && !err_o, "R1", "reset state",
          {count_o, empty_o, full_o, req_o, err_o}, 5'd0 << 4 | 5'b01000);
    @(negedge clk_i);
    rst_ni = 1;
    compare();
    // disabled, toward host: one byte per request
    wr(); wr(); rd(); rd();
    cyc();
    check(err_o == 1, "R10", "sticky err", err_o, 1);
    // enabled toward host, code 3 -> threshold 4, request at 12
    cfg(1, 3, 0);
    repeat (11) wr();
    check(req_o == 0, "R6", "below level", req_o, 0);
    wr();
    check(req_o == 1, "R6", "at level", req_o, 1);
    repeat (7) rd();
    check(req_o == 1, "R7", "held while draining", req_o, 1);
    repeat (5) rd();
    check(req_o == 0, "R7", "drop at empty", req_o, 0);
    // sector end flush
    repeat (3) wr();
    sector_end_i = 1; cyc();
    check(req_o == 1, "R8", "flush request", req_o, 1);
    repeat (3) rd();
    wr(); cyc();
    check(req_o == 0, "R8", "flush cleared at empty", req_o, 0);
    rd();
    // extreme codes
    cfg(1, 15, 0); wr(); rd();
    cfg(1, 0, 0); repeat (16) wr(); wr(); repeat (17) rd();
    // from host, code 7
    cfg(1, 7, 1);
    check(req_o == 1, "R9", "request after configure", req_o, 1);
    repeat (16) wr();
    check(req_o == 0, "R9", "drop at full", req_o, 0);
    wr();
    repeat (7) rd();
    check(req_o == 0, "R9", "free 7 below threshold", req_o, 0);
    rd();
    check(req_o == 1, "R9", "free 8 reasserts", req_o, 1);
    repeat (9) rd();
    // disabled, from host
    cfg(0, 0, 1);
    check(req_o == 1, "R3", "empty requests", req_o, 1);
    wr(); wr(); rd();
    // random mix with simultaneous access
    cfg(1, 5, 0);
    for (int i = 0; i < 400; i++) begin
      wr_i = ($urandom % 3) != 0; wr_data_i = wdat; wdat = wdat + 8'd1;
      rd_i = ($urandom % 2) != 0; sector_end_i = ($urandom % 23) == 0;
      cyc();
    end
    cfg(1, 9, 1);
    for (int i = 0; i < 400; i++) begin
      wr_i = ($urandom % 2) != 0; wr_data_i = wdat; wdat = wdat + 8'd1;
      rd_i = ($urandom % 3) == 0;
      cyc();
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule